// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is a 32-pin general-purpose I/O port that sits behind a simple word-addressed register bus. Each pin is either a plain input/output, an interrupt source, or one of three alternate peripheral functions. The active role comes from three per-pin configuration bits: function, select and trigger. Every configuration register has three addresses. The base address is read and written whole. The second address sets the bits written as 1, and the third clears them, so software changes single bits without a read-modify-write.

Pad inputs pass through a two-flop synchronizer. The synchronized level can be read back at all times and feeds a per-pin event detector. In interrupt mode the trigger bit chooses between edge and level detection, and the direction bit chooses the polarity. Detected events are latched in a flag register. The unmasked flags are ORed into one registered interrupt line. Toward the pads the block drives output data, output enable, pull enable, and one enable vector for each alternate function. The bus and the pad signals are plain control and status pins, with no valid/ready handshake and no back-pressure. A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled, and that data holds until the next read.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the mask register reads all ones and every other writable register (data, pull, function, select, direction, trigger, flag) reads zero. As a result every pin is a plain input with its pull enabled and `irq_o` is low.
- R2: Groups sit at byte offsets 0x10 data, 0x20 mask, 0x30 pull, 0x40 function, 0x50 select, 0x60 direction and 0x70 trigger. A write to a group's base replaces the register. A write to base+4 sets the bits written as 1, and a write to base+8 clears the bits written as 1. A read returns the addressed register one cycle after `bus_rd` and holds it until the next read.
- R3: Offset 0x00 reads the pad levels after two synchronizer flops, and offset 0x80 reads the flags. Writes to either address change nothing.
- R4: A pin's role is decoded from its function, select and trigger bits as follows. With function=0, select=0 it is plain GPIO, and with function=0, select=1 it is an interrupt input. With function=1, select=0 it is alternate 1. With function=1, select=1 it is alternate 2 when trigger=0 and alternate 3 when trigger=1. Exactly the matching `alt*_en` bit is high, and at most one of the alternate enables and the output enable is high per pin.
- R5: `pad_out` always equals the data register. `pad_oe` is high only for a plain GPIO pin whose direction bit is 1.
- R6: `pad_pull_en` is the inverse of the pull register, so a pull bit of 0 enables the pull.
- R7: In interrupt mode with trigger=1, a synchronized rising edge (direction=1) or falling edge (direction=0) sets the pin's flag. The flag stays set until software clears it.
- R8: In interrupt mode with trigger=0, the flag is set on every cycle that the synchronized level equals the direction bit. A clear while the level holds is overridden.
- R9: A write to offset 0x14 clears the flag for bits written as 1 on interrupt-mode pins. For all other pins it sets the data bits written as 1. Interrupt-mode pins keep their data bits.
- R10: The flag of a pin that is not in interrupt mode is forced to zero one cycle after the pin leaves that mode.
- R11: `irq_o` is the OR over all pins of flag AND NOT mask, registered one cycle. A mask bit of 1 blocks that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, valid the cycle after a read |
| pad_in | input | PINS | Raw pad levels |
| pad_out | output | PINS | Output data toward the pads |
| pad_oe | output | PINS | Output enable per pin |
| pad_pull_en | output | PINS | Pull resistor enable per pin |
| alt1_en | output | PINS | Alternate function 1 selected |
| alt2_en | output | PINS | Alternate function 2 selected |
| alt3_en | output | PINS | Alternate function 3 selected |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a level-mode flag that software clears while the pad still holds the active level. Catching it requires the clear write to land while the synchronized level persists, and a read to follow before the pad moves. The stimulus holds the pad high, writes the shared clear address, and reads the flag back with the pin still masked, then unmasks it to show the interrupt line following. The same shared address is exercised in one write that covers both an interrupt-mode pin and a plain pin. That single write shows the flag clear on one pin and the data set on the other.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // byte offsets of the fixed registers
  localparam logic [7:0] OFS_LEVEL  = 8'h00;
  localparam logic [7:0] OFS_SHARED = 8'h14;
  localparam logic [7:0] OFS_FLAG   = 8'h80;
  localparam logic [7:0] OFS_STRIDE = 8'h10;
  localparam logic [7:0] OFS_SET    = 8'h04;
  localparam logic [7:0] OFS_CLR    = 8'h08;

  // configuration groups, base = (index + 1) * OFS_STRIDE
  localparam int unsigned G_DATA     = 0;
  localparam int unsigned G_MASK     = 1;
  localparam int unsigned G_PULL     = 2;
  localparam int unsigned G_FUNC     = 3;
  localparam int unsigned G_SEL      = 4;
  localparam int unsigned G_DIR      = 5;
  localparam int unsigned G_TRIG     = 6;
  localparam int unsigned NUM_GROUPS = 7;

  typedef enum logic [2:0] {
    PM_GPIO = 3'd0,
    PM_IRQ  = 3'd1,
    PM_ALT1 = 3'd2,
    PM_ALT2 = 3'd3,
    PM_ALT3 = 3'd4
  } pin_mode_e;

  function automatic pin_mode_e decode_mode(input logic fn, input logic sel, input logic trg);
    pin_mode_e m;
    if (!fn)      m = sel ? PM_IRQ : PM_GPIO;
    else if (!sel) m = PM_ALT1;
    else          m = trg ? PM_ALT3 : PM_ALT2;
    return m;
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_wsc_reg.sv
module gpio_wsc_reg #(
  parameter int unsigned      W       = 32,
  parameter int unsigned      AW      = 8,
  parameter logic [AW-1:0]    BASE    = '0,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  set_gate,
  output logic [W-1:0]  q
);
  localparam logic [AW-1:0] SET_A = BASE + AW'(4);
  localparam logic [AW-1:0] CLR_A = BASE + AW'(8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      if (wr_addr == BASE)       q <= wr_data;
      else if (wr_addr == SET_A) q <= q | (wr_data & set_gate);
      else if (wr_addr == CLR_A) q <= q & ~wr_data;
    end
  end
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] trig,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, level_hit;
    assign rise      = lvl[i] & ~prev_q[i];
    assign fall      = ~lvl[i] & prev_q[i];
    assign level_hit = ~(lvl[i] ^ dir[i]);
    assign evt[i]    = trig[i] ? (dir[i] ? rise : fall) : level_hit;
  end
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] arm,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] flag_q,
  output logic         irq_o
);
  logic [W-1:0] flag_d;

  always_comb flag_d = ((flag_q & ~clr) | evt) & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_o  <= |(flag_q & ~mask);
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pull_en,
  output logic [PINS-1:0]   alt1_en,
  output logic [PINS-1:0]   alt2_en,
  output logic [PINS-1:0]   alt3_en,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_SHARED = ADDR_W'(OFS_SHARED);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(OFS_FLAG);

  logic [PINS-1:0] cfg_q [NUM_GROUPS];
  logic [PINS-1:0] data_q, mask_q, pull_q, func_q, sel_q, dir_q, trig_q;
  logic [PINS-1:0] lvl_sync, evt, flag_q, flag_clr;
  logic [PINS-1:0] irq_mode, gpio_mode;
  logic [PINS-1:0] rd_val;

  // configuration registers with set/clear aliases
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cfg
    gpio_wsc_reg #(
      .W      (PINS),
      .AW     (ADDR_W),
      .BASE   (ADDR_W'((g + 1) * 16)),
      .RST_VAL((g == G_MASK) ? {PINS{1'b1}} : {PINS{1'b0}})
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .wr_addr (bus_addr),
      .wr_data (bus_wdata),
      .set_gate((g == G_DATA) ? ~irq_mode : {PINS{1'b1}}),
      .q       (cfg_q[g])
    );
  end

  assign data_q = cfg_q[G_DATA];
  assign mask_q = cfg_q[G_MASK];
  assign pull_q = cfg_q[G_PULL];
  assign func_q = cfg_q[G_FUNC];
  assign sel_q  = cfg_q[G_SEL];
  assign dir_q  = cfg_q[G_DIR];
  assign trig_q = cfg_q[G_TRIG];

  // per-pin role decode
  for (genvar i = 0; i < PINS; i++) begin : g_mode
    pin_mode_e mode;
    assign mode         = decode_mode(func_q[i], sel_q[i], trig_q[i]);
    assign gpio_mode[i] = (mode == PM_GPIO);
    assign irq_mode[i]  = (mode == PM_IRQ);
    assign alt1_en[i]   = (mode == PM_ALT1);
    assign alt2_en[i]   = (mode == PM_ALT2);
    assign alt3_en[i]   = (mode == PM_ALT3);
  end

  assign pad_out     = data_q;
  assign pad_oe      = gpio_mode & dir_q;
  assign pad_pull_en = ~pull_q;

  gpio_pad_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (pad_in),
    .sync_o(lvl_sync)
  );

  gpio_event_det #(.W(PINS)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl_sync),
    .dir  (dir_q),
    .trig (trig_q),
    .evt  (evt)
  );

  assign flag_clr = (bus_wr && bus_addr == A_SHARED) ? (bus_wdata & irq_mode) : '0;

  gpio_flag_bank #(.W(PINS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .arm   (irq_mode),
    .clr   (flag_clr),
    .mask  (mask_q),
    .flag_q(flag_q),
    .irq_o (irq_o)
  );

  // read path
  always_comb begin
    rd_val = '0;
    if (bus_addr == A_LEVEL) rd_val = lvl_sync;
    if (bus_addr == A_FLAG)  rd_val = flag_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (bus_addr == ADDR_W'((g + 1) * 16)) rd_val = cfg_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  flag_q,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  data_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  trig_q,
  input logic [W-1:0]  irq_mode,
  input logic [W-1:0]  lvl_sync,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  alt1_en,
  input logic [W-1:0]  alt2_en,
  input logic [W-1:0]  alt3_en,
  input logic          irq_o
);
  logic [W-1:0] lvl_hit;
  logic [W-1:0] overlap;
  assign lvl_hit = irq_mode & ~trig_q & ~(lvl_sync ^ dir_q);
  assign overlap = (alt1_en & alt2_en) | (alt1_en & alt3_en) | (alt2_en & alt3_en)
                 | (pad_oe & (alt1_en | alt2_en | alt3_en));

  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~mask_q)) |=> irq_o);
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_q & ~mask_q)) |=> !irq_o);
  // R9
  shared_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h14)) |=> (((data_q ^ $past(data_q)) & $past(irq_mode)) == '0));
  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hit != '0) |=> ((flag_q & $past(lvl_hit)) == $past(lvl_hit)));
  // R4
  role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlap == '0);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(PINS), .AW(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .flag_q   (flag_q),
  .mask_q   (mask_q),
  .data_q   (data_q),
  .dir_q    (dir_q),
  .trig_q   (trig_q),
  .irq_mode (irq_mode),
  .lvl_sync (lvl_sync),
  .pad_oe   (pad_oe),
  .alt1_en  (alt1_en),
  .alt2_en  (alt2_en),
  .alt3_en  (alt3_en),
  .irq_o    (irq_o)
);

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
  localparam int unsigned W  = 32;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [W-1:0]  bus_wdata, bus_rdata, pad_in;
  logic [W-1:0]  pad_out, pad_oe, pad_pull_en, alt1_en, alt2_en, alt3_en;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;
  logic [W-1:0] mon_exp;
  string        mon_tag;

  always #10 clk = ~clk;

  gpio_irq_port #(.PINS(W), .ADDR_W(AW)) u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .alt1_en(alt1_en), .alt2_en(alt2_en),
    .alt3_en(alt3_en), .irq_o(irq_o)
  );

  task automatic check_vec(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic read_expect(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: read data with no expected entry, actual %h expected none", bus_rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check_vec(bus_rdata, mon_exp, mon_tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);

    // R1 reset state
    read_expect(8'h20, 32'hFFFF_FFFF, "R1 mask after reset");
    read_expect(8'h10, 32'h0, "R1 data after reset");
    read_expect(8'h80, 32'h0, "R1 flag after reset");
    check_vec({31'b0, irq_o}, 32'h0, "R1 irq after reset");
    check_vec(pad_oe, 32'h0, "R1 oe after reset");
    check_vec(pad_pull_en, 32'hFFFF_FFFF, "R6 pulls enabled after reset");

    // R2 base, set and clear aliases
    write_reg(8'h10, 32'h0000_00F0);
    write_reg(8'h14, 32'h0000_000F);
    write_reg(8'h18, 32'h0000_0081);
    read_expect(8'h10, 32'h0000_007E, "R2 data via base/set/clear");
    write_reg(8'h34, 32'hFFFF_0000);
    read_expect(8'h30, 32'hFFFF_0000, "R2 pull via set alias");
    check_vec(pad_pull_en, 32'h0000_FFFF, "R6 pull enable inverse");

    // R5 output drive
    write_reg(8'h64, 32'h0000_00FF);
    check_vec(pad_oe, 32'h0000_00FF, "R5 oe from direction");
    check_vec(pad_out, 32'h0000_007E, "R5 pad_out from data");
    write_reg(8'h68, 32'h0000_00FF);

    // R3 synchronized level, writes ignored
    pad_in = 32'hDEAD_0000;
    wait_cycles(3);
    read_expect(8'h00, 32'hDEAD_0000, "R3 pin level");
    write_reg(8'h00, 32'h0);
    write_reg(8'h80, 32'hFFFF_FFFF);
    read_expect(8'h00, 32'hDEAD_0000, "R3 level write ignored");
    read_expect(8'h80, 32'h0, "R3 flag write ignored");

    // R4 alternate role decode on pins 8..10
    write_reg(8'h44, 32'h0000_0700);
    write_reg(8'h54, 32'h0000_0600);
    write_reg(8'h74, 32'h0000_0400);
    check_vec(alt1_en, 32'h0000_0100, "R4 alt1");
    check_vec(alt2_en, 32'h0000_0200, "R4 alt2");
    check_vec(alt3_en, 32'h0000_0400, "R4 alt3");
    write_reg(8'h48, 32'h0000_0700);
    write_reg(8'h58, 32'h0000_0600);
    write_reg(8'h78, 32'h0000_0400);

    // R7 rising edge on pin 0
    write_reg(8'h74, 32'h1);
    write_reg(8'h64, 32'h1);
    write_reg(8'h54, 32'h1);
    write_reg(8'h28, 32'h1);
    pad_in[0] = 1'b1;
    wait_cycles(5);
    read_expect(8'h80, 32'h1, "R7 rising edge flag");
    check_vec({31'b0, irq_o}, 32'h1, "R11 irq from unmasked flag");
    wait_cycles(4);
    read_expect(8'h80, 32'h1, "R7 edge flag holds");
    // R9 shared offset: bit0 irq-mode clear, bit7 plain set
    write_reg(8'h14, 32'h0000_0081);
    wait_cycles(2);
    read_expect(8'h80, 32'h0, "R9 flag cleared");
    check_vec({31'b0, irq_o}, 32'h0, "R11 irq drops after clear");
    read_expect(8'h10, 32'h0000_00FE, "R9 data set only on plain pin");

    // R7 falling edge on pin 1
    pad_in[1] = 1'b1;
    wait_cycles(4);
    write_reg(8'h74, 32'h2);
    write_reg(8'h54, 32'h2);
    write_reg(8'h28, 32'h2);
    pad_in[1] = 1'b0;
    wait_cycles(5);
    read_expect(8'h80, 32'h2, "R7 falling edge flag");
    write_reg(8'h14, 32'h2);
    wait_cycles(1);
    read_expect(8'h80, 32'h0, "R7 falling flag cleared");

    // R8 level high on pin 2, still masked
    write_reg(8'h64, 32'h4);
    write_reg(8'h54, 32'h4);
    pad_in[2] = 1'b1;
    wait_cycles(5);
    read_expect(8'h80, 32'h4, "R8 level flag");
    check_vec({31'b0, irq_o}, 32'h0, "R11 masked flag blocked");
    write_reg(8'h14, 32'h4);
    wait_cycles(1);
    read_expect(8'h80, 32'h4, "R8 level flag re-asserts after clear");
    write_reg(8'h28, 32'h4);
    wait_cycles(2);
    check_vec({31'b0, irq_o}, 32'h1, "R11 irq after unmask");
    pad_in[2] = 1'b0;
    wait_cycles(4);
    write_reg(8'h14, 32'h4);
    wait_cycles(2);
    read_expect(8'h80, 32'h0, "R8 level flag clears once inactive");
    check_vec({31'b0, irq_o}, 32'h0, "R11 irq low again");

    // R10 leaving interrupt mode
    pad_in[0] = 1'b0;
    wait_cycles(4);
    pad_in[0] = 1'b1;
    wait_cycles(5);
    read_expect(8'h80, 32'h1, "R10 flag set before mode change");
    check_vec(pad_oe, 32'h0, "R5 no drive in interrupt mode");
    write_reg(8'h58, 32'h1);
    wait_cycles(3);
    read_expect(8'h80, 32'h0, "R10 flag forced clear");
    check_vec({31'b0, irq_o}, 32'h0, "R10 irq low after mode change");
    check_vec(pad_oe, 32'h1, "R5 drive after return to plain");

    wait_cycles(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule